// File: doc/BRIEF.md
# Packed Register-Pair Write Parser

This block takes a stream of 32-bit command words, one per valid/ready handshake, and finds command-packet headers in it. Packets whose opcode selects the packed register-pair format are turned into a sequence of single register writes. Each write has a 16-bit offset and a 32-bit value and leaves on a valid/ready write port. Packets with any other opcode, and any word that is not a command header, are consumed and produce no write.

A packed body starts with a register-count word. Groups of three words follow it: an offset word that carries two offsets, the value for the lower offset, and the value for the higher-half offset. The parser checks the rules these packets must meet. When one is broken it sets a sticky error flag and drops the rest of the packet. It still counts the dropped words, so the next header is found at the right place.

Top module: `pairpack_parser`

## Requirements
- R1: After a synchronous reset, `in_ready` is 1, `wr_valid` is 0 and `err` is 0.
- R2: A word with bits [31:30] = 2'b11 is a command header with body length field L in bits [29:16] (L+1 body words follow) and opcode in bits [15:8]; a word in header position with any other type is consumed alone and produces no write.
- R3: A command packet whose opcode is not 0xB9, 0xBB or 0xBD has all L+1 body words consumed without writes or error, even when those words look like headers.
- R4: For opcodes 0xB9, 0xBB and 0xBD the body is a count word C followed by C/2 groups: offset word (first offset in bits [15:0], second in bits [31:16]), first value, second value; writes come out first offset/first value, then second offset/second value, in group order.
- R5: While `wr_valid` is 1 and `wr_ready` is 0, `in_ready` is 0 and the write outputs hold steady.
- R6: A packed packet whose header bit 2 (filter reset) is 0 sets `err` and gives no writes.
- R7: An odd register count C sets `err`; no writes come from that packet.
- R8: For opcode 0xBD a count above 14 sets `err`; 14 is accepted, and 0xB9/0xBB accept 16.
- R9: Equal offsets inside one offset word, or a second offset equal to the next group's first offset, set `err`; writes from that group onward are dropped, and writes already made stand.
- R10: A count C with L ≠ 3·(C/2) sets `err` and drops the rest of the body.
- R11: `err` stays set until reset, and the packet after a failing packet is parsed and written normally.
- R12: Header bits 0 and 1 have no effect on the writes produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Parser accepts a word this cycle |
| in_data | input | 32 | Command word |
| wr_valid | output | 1 | Register write valid |
| wr_ready | input | 1 | Register write accepted |
| wr_offset | output | 16 | Register offset |
| wr_value | output | 32 | Register value |
| err | output | 1 | Sticky malformed-packet flag |

## Verification
The hardest case to reach is the offset collision across a group boundary. The offsets in each single word differ, so the break shows only when the second offset of one group is compared with the first offset of the next, after the first group's writes have already left. The stimulus builds that exact two-group packet. It expects only the first group's writes, then sends a clean packet to show the parser stayed aligned. Throttling of the write port runs during the multi-group packets, so stalls land on both the first and the second write of a group.

// File: rtl/pairpack_pkg.sv
package pairpack_pkg;
  typedef enum logic [2:0] {
    ST_HDR, ST_CNT, ST_OFS, ST_V0, ST_V1, ST_SKIP
  } pp_state_t;

  localparam logic [1:0] CMD_TYPE    = 2'b11;
  localparam logic [7:0] OP_CTX_PACK = 8'hB9;
  localparam logic [7:0] OP_SH_PACK  = 8'hBB;
  localparam logic [7:0] OP_SH_SHORT = 8'hBD;
  localparam int         FILT_BIT    = 2;
endpackage

// File: rtl/pp_hdr_decode.sv
module pp_hdr_decode
  import pairpack_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 14
) (
  input  logic [DATA_W-1:0] word,
  output logic              is_cmd,
  output logic [LEN_W-1:0]  len,
  output logic              packed_hit,
  output logic              short_hit,
  output logic              filt
);
  logic [7:0] op;
  always_comb begin
    op         = word[15:8];
    is_cmd     = (word[DATA_W-1 -: 2] == CMD_TYPE);
    len        = word[16 +: LEN_W];
    short_hit  = (op == OP_SH_SHORT);
    packed_hit = (op == OP_CTX_PACK) || (op == OP_SH_PACK) || short_hit;
    filt       = word[FILT_BIT];
  end
endmodule

// File: rtl/pp_count_check.sv
module pp_count_check #(
  parameter int DATA_W      = 32,
  parameter int LEN_W       = 14,
  parameter int SHORT_LIMIT = 14
) (
  input  logic [DATA_W-1:0] cnt_word,
  input  logic [LEN_W-1:0]  len,
  input  logic              short_mode,
  output logic              ok
);
  localparam int PW = DATA_W + 2;
  logic [PW-1:0] half;
  logic [PW-1:0] need;
  logic          even_ok, lim_ok, len_ok;
  always_comb begin
    half    = {3'b000, cnt_word[DATA_W-1:1]};
    need    = (half << 1) + half;
    even_ok = !cnt_word[0];
    lim_ok  = !short_mode || (cnt_word <= DATA_W'(SHORT_LIMIT));
    len_ok  = (need == PW'(len));
    ok      = even_ok && lim_ok && len_ok;
  end
endmodule

// File: rtl/pp_ofs_check.sv
module pp_ofs_check #(
  parameter int OFS_W = 16
) (
  input  logic [2*OFS_W-1:0] pair,
  input  logic [OFS_W-1:0]   prev_ofs,
  input  logic               prev_vld,
  output logic               ok
);
  logic [OFS_W-1:0] o0, o1;
  always_comb begin
    o0 = pair[OFS_W-1:0];
    o1 = pair[2*OFS_W-1:OFS_W];
    ok = (o0 != o1) && !(prev_vld && (prev_ofs == o0));
  end
endmodule

// File: rtl/pairpack_parser.sv
module pairpack_parser
  import pairpack_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int OFS_W       = 16,
  parameter int LEN_W       = 14,
  parameter int SHORT_LIMIT = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [OFS_W-1:0]  wr_offset,
  output logic [DATA_W-1:0] wr_value,
  output logic              err
);
  localparam int REM_W = LEN_W + 1;

  pp_state_t          st_q;
  logic [REM_W-1:0]   rem_q;
  logic [LEN_W-1:0]   len_q;
  logic               short_q;
  logic [2*OFS_W-1:0] pair_q;
  logic [OFS_W-1:0]   prev_q;
  logic               prev_v_q;
  logic               wv_q, err_q;
  logic [OFS_W-1:0]   wo_q;
  logic [DATA_W-1:0]  wd_q;

  logic             h_cmd, h_pack, h_short, h_filt;
  logic [LEN_W-1:0] h_len;
  logic             cnt_ok, ofs_ok;
  logic             accept, last;

  pp_hdr_decode #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_hdr (
    .word(in_data), .is_cmd(h_cmd), .len(h_len),
    .packed_hit(h_pack), .short_hit(h_short), .filt(h_filt)
  );

  pp_count_check #(.DATA_W(DATA_W), .LEN_W(LEN_W), .SHORT_LIMIT(SHORT_LIMIT)) u_cnt (
    .cnt_word(in_data), .len(len_q), .short_mode(short_q), .ok(cnt_ok)
  );

  pp_ofs_check #(.OFS_W(OFS_W)) u_ofs (
    .pair(in_data[2*OFS_W-1:0]), .prev_ofs(prev_q), .prev_vld(prev_v_q), .ok(ofs_ok)
  );

  assign in_ready  = !wv_q || wr_ready;
  assign accept    = in_valid && in_ready;
  assign last      = (rem_q == REM_W'(1));
  assign wr_valid  = wv_q;
  assign wr_offset = wo_q;
  assign wr_value  = wd_q;
  assign err       = err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_HDR;
      rem_q    <= '0;
      len_q    <= '0;
      short_q  <= 1'b0;
      pair_q   <= '0;
      prev_q   <= '0;
      prev_v_q <= 1'b0;
      wv_q     <= 1'b0;
      wo_q     <= '0;
      wd_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      if (wv_q && wr_ready) wv_q <= 1'b0;
      if (accept) begin
        if (st_q != ST_HDR) rem_q <= rem_q - REM_W'(1);
        unique case (st_q)
          ST_HDR: if (h_cmd) begin
            rem_q   <= REM_W'(h_len) + REM_W'(1);
            len_q   <= h_len;
            short_q <= h_short;
            if (h_pack && h_filt) st_q <= ST_CNT;
            else begin
              st_q <= ST_SKIP;
              if (h_pack) err_q <= 1'b1;
            end
          end
          ST_CNT: begin
            prev_v_q <= 1'b0;
            if (!cnt_ok) err_q <= 1'b1;
            if (last) st_q <= ST_HDR;
            else st_q <= cnt_ok ? ST_OFS : ST_SKIP;
          end
          ST_OFS: begin
            if (ofs_ok) begin
              pair_q   <= in_data[2*OFS_W-1:0];
              prev_q   <= in_data[2*OFS_W-1:OFS_W];
              prev_v_q <= 1'b1;
              st_q     <= ST_V0;
            end else begin
              err_q <= 1'b1;
              st_q  <= last ? ST_HDR : ST_SKIP;
            end
          end
          ST_V0: begin
            wv_q <= 1'b1;
            wo_q <= pair_q[OFS_W-1:0];
            wd_q <= in_data;
            st_q <= ST_V1;
          end
          ST_V1: begin
            wv_q <= 1'b1;
            wo_q <= pair_q[2*OFS_W-1:OFS_W];
            wd_q <= in_data;
            st_q <= last ? ST_HDR : ST_OFS;
          end
          default: if (last) st_q <= ST_HDR;
        endcase
      end
    end
  end
endmodule

// File: rtl/pp_parser_chk.sv
module pp_parser_chk #(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [OFS_W-1:0]  wr_offset,
  input logic [DATA_W-1:0] wr_value,
  input logic              err
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!wr_valid && !err && in_ready));

  p_stall_blocks_input_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |-> !in_ready);

  p_stall_holds_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_offset) && $stable(wr_value)));

  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  p_write_from_input_r4: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $rose(wr_valid) |-> $past(in_valid && in_ready));
endmodule

bind pairpack_parser pp_parser_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_offset(wr_offset),
  .wr_value(wr_value), .err(err)
);

// File: tb/pairpack_parser_tb.sv
module pairpack_parser_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [15:0] wr_offset;
  logic [31:0] wr_value;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;
  bit bp = 1'b0;
  logic [47:0] expq[$];

  always #5 clk = ~clk;

  pairpack_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_offset(wr_offset),
    .wr_value(wr_value), .err(err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [7:0] op, input int n, input logic [2:0] fl);
    return {2'b11, n[13:0], op, 5'b00000, fl};
  endfunction

  // write-port throttle: changes 1 ns after the rising edge
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      wr_ready = bp ? ((k % 3) != 0) : 1'b1;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wr_valid && !wr_ready && in_ready)
      chk(1'b0, "R5 input not held off", 64'(in_ready), 64'd0);
    if (!rst && wr_valid && wr_ready) begin
      if (expq.size() == 0)
        chk(1'b0, "R4 unexpected write", {16'd0, wr_offset, wr_value}, 64'd0);
      else begin
        logic [47:0] e;
        e = expq.pop_front();
        chk({wr_offset, wr_value} == e, "R4 write content", {16'd0, wr_offset, wr_value}, {16'd0, e});
      end
    end
  end

  task automatic send(input logic [31:0] w);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    forever begin
      #4 acc = in_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input string req, input logic exp_err);
    repeat (30) @(negedge clk);
    chk(expq.size() == 0, req, 64'(expq.size()), 64'd0);
    chk(err == exp_err, req, 64'(err), 64'(exp_err));
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
  endtask

  // well-formed packed packet; offsets base+i, values tag+offset
  task automatic pkt_good(input logic [7:0] op, input logic [2:0] fl, input int rc,
                          input logic [15:0] base, input logic [31:0] tag);
    for (int i = 0; i < rc; i++) expq.push_back({base + 16'(i), tag + 32'(base) + 32'(i)});
    send(hdr(op, 3 * (rc / 2), fl));
    send(32'(rc));
    for (int g = 0; g < rc / 2; g++) begin
      logic [15:0] a, b;
      a = base + 16'(2 * g);
      b = a + 16'd1;
      send({b, a});
      send(tag + 32'(a));
      send(tag + 32'(b));
    end
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
    chk(wr_valid == 1'b0, "R1 wr_valid after reset", 64'(wr_valid), 64'd0);
    chk(err == 1'b0, "R1 err after reset", 64'(err), 64'd0);

    send(32'h8000_0000);                 // R2: non-command word
    drain("R2 filler word", 1'b0);

    send(hdr(8'h10, 2, 3'b000));         // R3: unknown opcode, body mimics headers
    send(hdr(8'hB9, 3, 3'b100));
    send(32'd2);
    send(32'h0002_0001);
    pkt_good(8'hB9, 3'b100, 2, 16'h0100, 32'hA000_0000);
    drain("R3 unknown opcode skipped", 1'b0);

    bp = 1'b1;
    pkt_good(8'hB9, 3'b100, 4, 16'h0200, 32'hB000_0000);   // R4 R5
    drain("R4 R5 packed under backpressure", 1'b0);
    pkt_good(8'hBB, 3'b111, 2, 16'h0300, 32'hC000_0000);   // R12
    drain("R12 predicate and shader bits", 1'b0);
    pkt_good(8'hBD, 3'b100, 14, 16'h0400, 32'hD000_0000);  // R8 limit
    drain("R8 short variant at 14", 1'b0);
    pkt_good(8'hB9, 3'b100, 16, 16'h0500, 32'hE000_0000);  // R8 long variant
    drain("R8 long variant 16", 1'b0);
    bp = 1'b0;
    pkt_good(8'hBB, 3'b100, 0, 16'h0000, 32'h0);           // R4 empty
    drain("R4 zero count", 1'b0);

    do_reset();                          // R6 then R11
    send(hdr(8'hB9, 3, 3'b000));
    send(32'd2); send(32'h0002_0001); send(32'h11); send(32'h22);
    drain("R6 filter bit clear", 1'b1);
    pkt_good(8'hBB, 3'b100, 2, 16'h0600, 32'hF000_0000);
    drain("R11 aligned after error", 1'b1);

    do_reset();                          // R7
    send(hdr(8'hB9, 3, 3'b100));
    send(32'd3); send(32'h0002_0001); send(32'h1); send(32'h2);
    drain("R7 odd count", 1'b1);

    do_reset();                          // R8 over limit
    send(hdr(8'hBD, 24, 3'b100));
    send(32'd16);
    for (int i = 0; i < 24; i++) send(32'h0010_0000 + 32'(i));
    drain("R8 short variant over 14", 1'b1);

    do_reset();                          // R9 inside one word
    expq.push_back({16'h0020, 32'h5555_0020});
    expq.push_back({16'h0021, 32'h5555_0021});
    send(hdr(8'hB9, 6, 3'b100));
    send(32'd4);
    send(32'h0021_0020); send(32'h5555_0020); send(32'h5555_0021);
    send(32'h0030_0030); send(32'h1); send(32'h2);
    drain("R9 equal offsets in group", 1'b1);

    do_reset();                          // R9 across groups
    bp = 1'b1;
    expq.push_back({16'h0005, 32'h6666_0005});
    expq.push_back({16'h0006, 32'h6666_0006});
    send(hdr(8'hBB, 6, 3'b100));
    send(32'd4);
    send(32'h0006_0005); send(32'h6666_0005); send(32'h6666_0006);
    send(32'h0007_0006); send(32'h3); send(32'h4);
    drain("R9 equal offsets across groups", 1'b1);
    pkt_good(8'hB9, 3'b100, 4, 16'h0700, 32'h7000_0000);
    drain("R11 aligned after collision", 1'b1);
    bp = 1'b0;

    do_reset();                          // R10
    send(hdr(8'hBB, 5, 3'b100));
    send(32'd2);
    send(32'h0002_0001); send(32'h9); send(32'h9);
    send(hdr(8'hB9, 3, 3'b100)); send(32'd2);
    pkt_good(8'hBD, 3'b100, 2, 16'h0800, 32'h8000_0000);
    drain("R10 length mismatch then R11", 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule